// File: doc/BRIEF.md
# Host clock divider and reset sequencer

This block derives a host-domain clock enable from a fast system clock by integer division. It also orders the reset releases of two downstream domains: a PHY clock domain and a host-controller clock domain. Control arrives as register-style levels: a divisor value with a write strobe, an active-low divider hold, a divider enable, a bypass bit, and one release request bit for each domain. Both destination clocks are modelled as enable ticks on the system clock. The host tick is the divider output. The PHY tick comes from outside.

The divisor may only be loaded while the divider is held, and only from a fixed set of legal values. Each domain reset output is made by a two-stage synchronizer that steps on that domain's tick. The synchronizer asserts at once and releases only on ticks. A release request is honoured only after its minimum delay has passed. The PHY release waits for six ticks of both the host tick and the PHY tick. The host release waits a programmable number of milliseconds of stable PHY reset, counted in system clock cycles. A request that arrives too early raises a sticky flag.

Top module: `hclk_rst_seq`

## Requirements
- R1: After core reset the tick output and both domain reset outputs are 0, all three sticky flags are 0, and the divisor is DEF_DIV (4 by default).
- R2: With the divider out of hold, enabled and not bypassed, hclk_ce pulses once every N system cycles for divisor N. The counter restarts from zero when the hold is lifted.
- R3: A divisor write is accepted only for the values 1, 2, 3, 4, 6, 8 and 12. A write of any other 4-bit value leaves the previous divisor in place and does not set div_err.
- R4: A divisor write (div_wr=1) while div_rst_n=1 is ignored and sets div_err. div_err stays set until core reset.
- R5: hclk_ce is 0 while div_rst_n=0, while div_en=0, or while rst_n=0. Core reset also returns the divisor to DEF_DIV.
- R6: With div_byp=1, the divider out of hold and div_en=1, hclk_ce is 1 on every system cycle.
- R7: An accepted PHY release is registered once and then passes two synchronizer stages. The stages advance only on cycles with phy_ce=1.
- R8: The PHY release is held off until at least 6 hclk_ce pulses and 6 phy_ce pulses have occurred since core reset. A request made before then sets phy_early.
- R9: The host release is held off until phy_rst_n_o has been 1 for HOST_WAIT_MS*CYC_PER_MS system cycles. A request made before then sets host_early.
- R10: An accepted host release passes two synchronizer stages that advance only on cycles with hclk_ce=1.
- R11: When a release request drops to 0, the matching reset output is 0 in the cycle after the next clock edge. When phy_rst_n_o falls, the host wait restarts, so the host reset also re-asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Core reset, asynchronous, active low |
| div_val | input | DIV_W | Divisor value to load |
| div_wr | input | 1 | Divisor write strobe |
| div_rst_n | input | 1 | Divider hold, active low |
| div_en | input | 1 | Divider output enable |
| div_byp | input | 1 | Pass the system clock through undivided |
| phy_ce | input | 1 | PHY clock tick |
| phy_rst_req | input | 1 | Request to release the PHY domain reset |
| host_rst_req | input | 1 | Request to release the host domain reset |
| hclk_ce | output | 1 | Divided host clock enable |
| phy_rst_n_o | output | 1 | PHY domain reset, active low |
| host_rst_n_o | output | 1 | Host domain reset, active low |
| div_err | output | 1 | Sticky: divisor written while the divider was running |
| phy_early | output | 1 | Sticky: PHY release requested before its delay had passed |
| host_early | output | 1 | Sticky: host release requested before its delay had passed |

## Verification
hclk_ce is combinational from the registered counter and the current inputs, so it is due in the same cycle as the input change. A divisor write or a change of hold takes effect after the next edge. A release request shows at a reset output no earlier than one edge for the registered release plus two ticks of the destination domain. A dropped request shows after exactly one edge. The bench changes inputs just after the falling edge and samples at the falling edge. It steps a behavioural model forward on each rising edge and compares every output on every cycle. Directed checks count hclk_ce pulses over windows that are whole multiples of the divisor, and they probe the reset outputs at the computed edge counts.

// File: rtl/hcrs_pkg.sv
package hcrs_pkg;
   localparam int NDOM     = 2;
   localparam int DOM_PHY  = 0;
   localparam int DOM_HOST = 1;

   // legal divisor set; all other codes are reserved
   function automatic logic div_is_legal(input int unsigned v);
      case (v)
         1, 2, 3, 4, 6, 8, 12: return 1'b1;
         default:              return 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/hcrs_clkdiv.sv
module hcrs_clkdiv #(
   parameter int DIV_W     = 4,
   parameter int DEF_DIV   = 4,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_val,
   input  logic             div_wr,
   input  logic             div_rst_n,
   input  logic             div_en,
   input  logic             div_byp,
   output logic             hclk_ce,
   output logic [DIV_W-1:0] div_cur,
   output logic             div_err
);
   import hcrs_pkg::*;

   if (DIV_W < 4) begin : g_bad_width
      $error("hcrs_clkdiv: DIV_W must be at least 4");
   end
   if (DEF_DIV < 1 || DEF_DIV >= (1 << DIV_W)) begin : g_bad_default
      $error("hcrs_clkdiv: DEF_DIV out of range");
   end

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] cnt_q;
   logic             err_q;
   logic             wrap;
   logic             pick;

   assign wrap = (cnt_q == div_q - DIV_W'(1));

   if (BYPASS_EN) begin : g_byp
      assign pick = div_byp | wrap;
   end else begin : g_nobyp
      assign pick = wrap;
   end

   assign hclk_ce = rst_n & div_rst_n & div_en & pick;
   assign div_cur = div_q;
   assign div_err = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= DIV_W'(DEF_DIV);
         cnt_q <= '0;
         err_q <= 1'b0;
      end else begin
         if (div_wr) begin
            if (div_rst_n)
               err_q <= 1'b1;
            else if (div_is_legal(int'(div_val)))
               div_q <= div_val;
         end
         if (!div_rst_n)
            cnt_q <= '0;
         else if (div_en)
            cnt_q <= wrap ? '0 : cnt_q + DIV_W'(1);
      end
   end
endmodule

// File: rtl/hcrs_rst_sync.sv
module hcrs_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic tick,
   output logic rst_n_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hcrs_rst_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)
         sh_q <= '0;
      else if (tick)
         sh_q <= {sh_q[STAGES-2:0], 1'b1};
   end

   assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/hcrs_guard.sv
module hcrs_guard #(
   parameter int PHY_WAIT     = 6,
   parameter int CYC_PER_MS   = 125000,
   parameter int HOST_WAIT_MS = 12
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [hcrs_pkg::NDOM-1:0] dom_tick,
   input  logic                      phy_up,
   input  logic                      phy_req,
   input  logic                      host_req,
   output logic                      phy_rel,
   output logic                      host_rel,
   output logic                      phy_early,
   output logic                      host_early
);
   import hcrs_pkg::*;

   localparam int HW  = $clog2(PHY_WAIT + 1);
   localparam int LIM = CYC_PER_MS * HOST_WAIT_MS;
   localparam int TW  = $clog2(LIM + 1);

   if (PHY_WAIT < 1 || CYC_PER_MS < 1 || HOST_WAIT_MS < 1) begin : g_bad_wait
      $error("hcrs_guard: wait parameters must be positive");
   end

   logic [HW-1:0]   wait_cnt [NDOM];
   logic [NDOM-1:0] dom_ready;
   logic [TW-1:0]   t_q;
   logic            phy_ok;
   logic            host_ok;

   // one saturating tick counter per clock domain
   for (genvar g = 0; g < NDOM; g++) begin : g_wait
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            wait_cnt[g] <= '0;
         else if (dom_tick[g] && !dom_ready[g])
            wait_cnt[g] <= wait_cnt[g] + HW'(1);
      end
      assign dom_ready[g] = (wait_cnt[g] == HW'(PHY_WAIT));
   end

   assign phy_ok  = &dom_ready;
   assign host_ok = (t_q == TW'(LIM));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t_q        <= '0;
         phy_rel    <= 1'b0;
         host_rel   <= 1'b0;
         phy_early  <= 1'b0;
         host_early <= 1'b0;
      end else begin
         if (!phy_up)
            t_q <= '0;
         else if (!host_ok)
            t_q <= t_q + TW'(1);
         phy_rel    <= phy_req & phy_ok;
         host_rel   <= host_req & host_ok;
         phy_early  <= phy_early | (phy_req & ~phy_ok);
         host_early <= host_early | (host_req & ~host_ok);
      end
   end
endmodule

// File: rtl/hclk_rst_seq.sv
module hclk_rst_seq #(
   parameter int DIV_W        = 4,
   parameter int DEF_DIV      = 4,
   parameter bit BYPASS_EN    = 1'b1,
   parameter int SYNC_STAGES  = 2,
   parameter int PHY_WAIT     = 6,
   parameter int CYC_PER_MS   = 125000,
   parameter int HOST_WAIT_MS = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_val,
   input  logic             div_wr,
   input  logic             div_rst_n,
   input  logic             div_en,
   input  logic             div_byp,
   input  logic             phy_ce,
   input  logic             phy_rst_req,
   input  logic             host_rst_req,
   output logic             hclk_ce,
   output logic             phy_rst_n_o,
   output logic             host_rst_n_o,
   output logic             div_err,
   output logic             phy_early,
   output logic             host_early
);
   import hcrs_pkg::*;

   logic [DIV_W-1:0] div_cur;
   logic [NDOM-1:0]  dom_tick;
   logic [NDOM-1:0]  dom_rel;
   logic [NDOM-1:0]  dom_rst_n;
   logic             phy_rel;
   logic             host_rel;

   hcrs_clkdiv #(
      .DIV_W(DIV_W), .DEF_DIV(DEF_DIV), .BYPASS_EN(BYPASS_EN)
   ) u_div (
      .clk(clk), .rst_n(rst_n), .div_val(div_val), .div_wr(div_wr),
      .div_rst_n(div_rst_n), .div_en(div_en), .div_byp(div_byp),
      .hclk_ce(hclk_ce), .div_cur(div_cur), .div_err(div_err)
   );

   assign dom_tick[DOM_PHY]  = phy_ce;
   assign dom_tick[DOM_HOST] = hclk_ce;
   assign dom_rel[DOM_PHY]   = phy_rel;
   assign dom_rel[DOM_HOST]  = host_rel;

   hcrs_guard #(
      .PHY_WAIT(PHY_WAIT), .CYC_PER_MS(CYC_PER_MS), .HOST_WAIT_MS(HOST_WAIT_MS)
   ) u_guard (
      .clk(clk), .rst_n(rst_n), .dom_tick(dom_tick),
      .phy_up(dom_rst_n[DOM_PHY]), .phy_req(phy_rst_req), .host_req(host_rst_req),
      .phy_rel(phy_rel), .host_rel(host_rel),
      .phy_early(phy_early), .host_early(host_early)
   );

   for (genvar g = 0; g < NDOM; g++) begin : g_sync
      hcrs_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk(clk), .arst_n(rst_n & dom_rel[g]),
         .tick(dom_tick[g]), .rst_n_o(dom_rst_n[g])
      );
   end

   assign phy_rst_n_o  = dom_rst_n[DOM_PHY];
   assign host_rst_n_o = dom_rst_n[DOM_HOST];
endmodule

// File: rtl/hclk_rst_seq_chk.sv
module hclk_rst_seq_chk #(
   parameter int DIV_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [DIV_W-1:0] div_val,
   input logic             div_wr,
   input logic             div_rst_n,
   input logic             hclk_ce,
   input logic             div_err,
   input logic             phy_ce,
   input logic             phy_rst_req,
   input logic             host_rst_req,
   input logic             phy_rst_n_o,
   input logic             host_rst_n_o,
   input logic [DIV_W-1:0] div_cur
);
   // R3
   div_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(div_wr && !div_rst_n) |=> $stable(div_cur));
   // R3
   div_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (div_wr && !hcrs_pkg::div_is_legal(int'(div_val))) |=> $stable(div_cur));
   // R4
   err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(div_err) |-> $past(div_wr) && $past(div_rst_n));
   // R4
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_err |=> div_err);
   // R5
   div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !div_rst_n |-> !hclk_ce);
   // R7
   phy_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phy_rst_n_o) |-> $past(phy_ce) && $past(phy_rst_req, 2));
   // R10
   host_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_rst_n_o) |-> $past(hclk_ce) && $past(host_rst_req, 2));
   // R11
   phy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !phy_rst_req |=> !phy_rst_n_o);
   // R11
   host_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rst_req |=> !host_rst_n_o);
endmodule

bind hclk_rst_seq hclk_rst_seq_chk #(.DIV_W(DIV_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .div_val(div_val), .div_wr(div_wr),
   .div_rst_n(div_rst_n), .hclk_ce(hclk_ce), .div_err(div_err),
   .phy_ce(phy_ce), .phy_rst_req(phy_rst_req), .host_rst_req(host_rst_req),
   .phy_rst_n_o(phy_rst_n_o), .host_rst_n_o(host_rst_n_o), .div_cur(div_cur)
);

// File: tb/hclk_rst_seq_test.sv
module hclk_rst_seq_test;
   localparam int DW   = 4;
   localparam int DEFD = 4;
   localparam int PW   = 6;
   localparam int CPM  = 5;
   localparam int HMS  = 12;
   localparam int LIM  = CPM * HMS;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n = 1'b1;
   logic [DW-1:0] div_val = '0;
   logic          div_wr = 1'b0, div_rst_n = 1'b0, div_en = 1'b0, div_byp = 1'b0;
   logic          phy_ce = 1'b0, phy_rst_req = 1'b0, host_rst_req = 1'b0;
   logic          hclk_ce, phy_rst_n_o, host_rst_n_o, div_err, phy_early, host_early;

   hclk_rst_seq #(
      .DIV_W(DW), .DEF_DIV(DEFD), .BYPASS_EN(1'b1), .SYNC_STAGES(2),
      .PHY_WAIT(PW), .CYC_PER_MS(CPM), .HOST_WAIT_MS(HMS)
   ) uut (
      .clk(clk), .rst_n(rst_n), .div_val(div_val), .div_wr(div_wr),
      .div_rst_n(div_rst_n), .div_en(div_en), .div_byp(div_byp),
      .phy_ce(phy_ce), .phy_rst_req(phy_rst_req), .host_rst_req(host_rst_req),
      .hclk_ce(hclk_ce), .phy_rst_n_o(phy_rst_n_o), .host_rst_n_o(host_rst_n_o),
      .div_err(div_err), .phy_early(phy_early), .host_early(host_early)
   );

   int    n_chk = 0, n_bad = 0;
   string phase = "R1";
   bit    chk_on = 1'b0, done = 1'b0, phy_run = 1'b0;

   // behavioural reference state
   int m_div = DEFD, m_cnt = 0, m_err = 0, m_hcnt = 0, m_pcnt = 0, m_tcnt = 0;
   int m_prel = 0, m_ps0 = 0, m_ps1 = 0, m_hrel = 0, m_hs0 = 0, m_hs1 = 0;
   int m_pearly = 0, m_hearly = 0;

   function automatic bit legal(int v);
      return v inside {1, 2, 3, 4, 6, 8, 12};
   endfunction

   function automatic int m_ce();
      return (rst_n && div_rst_n && div_en && (div_byp || m_cnt == m_div - 1)) ? 1 : 0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_div = DEFD; m_cnt = 0; m_err = 0; m_hcnt = 0; m_pcnt = 0; m_tcnt = 0;
         m_prel = 0; m_ps0 = 0; m_ps1 = 0; m_hrel = 0; m_hs0 = 0; m_hs1 = 0;
         m_pearly = 0; m_hearly = 0;
      end else begin
         int ce, pok, hok, n_prel, n_hrel, n_cnt;
         ce  = m_ce();
         pok = (m_hcnt == PW && m_pcnt == PW) ? 1 : 0;
         hok = (m_tcnt == LIM) ? 1 : 0;
         if (!div_rst_n) n_cnt = 0;
         else if (div_en) n_cnt = (m_cnt == m_div - 1) ? 0 : m_cnt + 1;
         else n_cnt = m_cnt;
         if (div_wr) begin
            if (div_rst_n) m_err = 1;
            else if (legal(int'(div_val))) m_div = int'(div_val);
         end
         m_cnt = n_cnt;
         if (ce != 0 && m_hcnt < PW) m_hcnt++;
         if (phy_ce && m_pcnt < PW) m_pcnt++;
         m_tcnt = (m_ps1 == 0) ? 0 : (hok != 0 ? LIM : m_tcnt + 1);
         n_prel = (phy_rst_req && pok != 0) ? 1 : 0;
         if (phy_rst_req && pok == 0) m_pearly = 1;
         n_hrel = (host_rst_req && hok != 0) ? 1 : 0;
         if (host_rst_req && hok == 0) m_hearly = 1;
         if (n_prel == 0) begin m_ps0 = 0; m_ps1 = 0; end
         else if (m_prel != 0 && phy_ce) begin m_ps1 = m_ps0; m_ps0 = 1; end
         if (n_hrel == 0) begin m_hs0 = 0; m_hs1 = 0; end
         else if (m_hrel != 0 && ce != 0) begin m_hs1 = m_hs0; m_hs0 = 1; end
         m_prel = n_prel;
         m_hrel = n_hrel;
      end
   end

   task automatic check1(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the reference model
   always @(negedge clk) begin
      if (chk_on && !done) begin
         check1(phase, "hclk_ce",      int'(hclk_ce),      m_ce());
         check1(phase, "phy_rst_n_o",  int'(phy_rst_n_o),  m_ps1);
         check1(phase, "host_rst_n_o", int'(host_rst_n_o), m_hs1);
         check1(phase, "div_err",      int'(div_err),      m_err);
         check1(phase, "phy_early",    int'(phy_early),    m_pearly);
         check1(phase, "host_early",   int'(host_early),   m_hearly);
      end
   end

   // PHY tick: one in three cycles once running
   initial begin
      int k = 0;
      forever begin
         @(negedge clk); #1;
         phy_ce = phy_run && (k % 3 == 0);
         k++;
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic count(string tag, int n, int exp);
      int c = 0;
      repeat (n) begin
         @(negedge clk);
         if (hclk_ce) c++;
      end
      #1;
      check1(tag, "pulse count", c, exp);
   endtask

   task automatic wr_div(int v);
      div_val = DW'(v); div_wr = 1'b1;
      step(1);
      div_wr = 1'b0;
   endtask

   task automatic setdiv(int v);
      div_rst_n = 1'b0;
      step(1);
      wr_div(v);
      div_rst_n = 1'b1;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_bad++;
         $display("FAIL R1 watchdog act=running exp=finished");
         finish_run();
      end
   end

   initial begin
      #1 rst_n = 1'b0;
      #1 chk_on = 1'b1;
      step(3);
      phase = "R1";
      check1("R1", "reset hclk_ce", int'(hclk_ce), 0);
      check1("R1", "reset phy_rst_n_o", int'(phy_rst_n_o), 0);
      check1("R1", "reset host_rst_n_o", int'(host_rst_n_o), 0);
      check1("R1", "reset div_err", int'(div_err), 0);
      rst_n = 1'b1; phy_run = 1'b1;
      step(2);

      phase = "R8";
      phy_rst_req = 1'b1;
      step(3);
      check1("R8", "early phy flag", int'(phy_early), 1);
      check1("R8", "early phy held", int'(phy_rst_n_o), 0);
      phy_rst_req = 1'b0;
      step(1);

      phase = "R1";
      div_rst_n = 1'b1; div_en = 1'b1;
      count("R1", 40, 10);

      phase = "R4";
      wr_div(2);
      check1("R4", "div_err after running write", int'(div_err), 1);
      count("R4", 40, 10);

      phase = "R3";
      div_rst_n = 1'b0;
      step(1);
      wr_div(5); wr_div(0); wr_div(15); wr_div(7);
      div_rst_n = 1'b1;
      count("R3", 60, 15);

      phase = "R2";
      foreach (legal_list[i]) begin
         setdiv(legal_list[i]);
         count("R2", 48, 48 / legal_list[i]);
      end

      phase = "R5";
      div_en = 1'b0;
      count("R5", 20, 0);
      div_en = 1'b1; div_rst_n = 1'b0;
      count("R5", 20, 0);
      div_rst_n = 1'b1;

      phase = "R6";
      div_byp = 1'b1;
      count("R6", 20, 20);
      div_byp = 1'b0;
      setdiv(3);

      phase = "R7";
      phy_rst_req = 1'b1;
      step(20);
      check1("R7", "phy released", int'(phy_rst_n_o), 1);

      phase = "R9";
      host_rst_req = 1'b1;
      step(3);
      check1("R9", "early host flag", int'(host_early), 1);
      check1("R9", "early host held", int'(host_rst_n_o), 0);
      host_rst_req = 1'b0;
      step(70);

      phase = "R10";
      host_rst_req = 1'b1;
      step(20);
      check1("R10", "host released", int'(host_rst_n_o), 1);

      phase = "R11";
      phy_rst_req = 1'b0;
      step(1);
      check1("R11", "phy re-asserted", int'(phy_rst_n_o), 0);
      step(2);
      check1("R11", "host re-asserted", int'(host_rst_n_o), 0);

      phase = "R5";
      host_rst_req = 1'b0;
      rst_n = 1'b0;
      step(2);
      check1("R5", "core reset hclk_ce", int'(hclk_ce), 0);
      check1("R5", "core reset div_err", int'(div_err), 0);
      check1("R5", "core reset phy_early", int'(phy_early), 0);
      rst_n = 1'b1;
      count("R5", 40, 10);

      step(2);
      finish_run();
   end

   int legal_list [7] = '{1, 2, 3, 4, 6, 8, 12};
endmodule